// File: doc/BRIEF.md
# Cursor Generator Host Register Port

This block is the host-facing side of a hardware cursor generator. A host reaches every internal location through one 16-bit address pointer. It loads the pointer in two byte writes. It then reads or writes through one of two data windows. The first window reaches a small file of 8-bit control registers: the command byte, the 12-bit cursor position, and the origin and extent of the crosshair window. The second window reaches 16-bit words of an external cursor bitmap RAM, which this block strobes.

Every access through either data window steps the pointer by one. A host can therefore set the pointer once and stream a run of registers or a whole bitmap. The decoded command fields and the coordinate values leave the block as plain outputs for the pixel-time overlay logic.

The host bus is a simple strobe interface. `port_sel` picks the target: 0 = pointer low byte, 1 = pointer high byte, 2 = bitmap RAM window, 3 = control register window. `wr_stb` takes priority over `rd_stb`. Read data is combinational in the strobe cycle. Writes and pointer steps take effect at the clock edge that ends that cycle.

Top module: `curs_regport`

## Requirements
- R1: A write to port 0 stages a low address byte. A following write to port 1 loads the pointer with {high byte, staged byte}. Reading port 0 or port 1 returns pointer bits 7:0 or 15:8 in rdata[7:0], with rdata[15:8] zero.
- R2: A write to port 1 that has no port 0 write since the last pointer load leaves the pointer unchanged.
- R3: Each read or write strobe on port 2 or port 3 advances the pointer by one, and 0xFFFF advances to 0x0000. Accesses to ports 0 and 1 never step it.
- R4: The control register window maps indices as follows: 0 command, 1/2 cursor X low/high, 3/4 cursor Y low/high, 5/6 window X low/high, 7/8 window Y low/high, 9/10 window width low/high, 11/12 window height low/high. A write takes wdata[7:0]. A read returns {8'h00, value}.
- R5: Only bits 3:0 of the cursor X and Y high registers are stored; their upper bits read as zero. cur_x and cur_y are 12 bits wide. The window values are 16 bits wide.
- R6: Command byte decode: bit 6 drives cursor_on, bit 5 drives xhair_on, bit 4 drives or_mode (1 = OR, 0 = XOR), bits 3:2 drive mux_mode (00 1:1, 01 4:1, 10 5:1), and bits 1:0 drive xhair_thick (00..11 = 1, 3, 5, 7 pixels). Bit 7 is not stored.
- R7: Register-window pointer values 0x000D and above read as zero, and writes to them change no register.
- R8: With the pointer below 0x0200, a port 2 write raises ram_we in that cycle, with ram_addr equal to the pointer and ram_wdata equal to wdata. A port 2 read raises ram_re and returns ram_rdata on rdata in that cycle.
- R9: With the pointer at 0x0200 or above, a port 2 access raises neither ram_we nor ram_re, and a read returns zero. The pointer still steps.
- R10: Reset clears the pointer, all registers and all decoded outputs, so the cursor and crosshair are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 2 | Host target select |
| wr_stb | input | 1 | Host write strobe |
| rd_stb | input | 1 | Host read strobe |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, valid in the strobe cycle |
| ram_we | output | 1 | Bitmap RAM write strobe |
| ram_re | output | 1 | Bitmap RAM read strobe |
| ram_addr | output | 9 | Bitmap RAM word address |
| ram_wdata | output | 16 | Bitmap RAM write data |
| ram_rdata | input | 16 | Bitmap RAM read data, combinational |
| cursor_on | output | 1 | Cursor enable |
| xhair_on | output | 1 | Crosshair enable |
| or_mode | output | 1 | Cursor combine mode |
| mux_mode | output | 2 | Pixel multiplex mode |
| xhair_thick | output | 2 | Crosshair thickness code |
| cur_x | output | 12 | Cursor X |
| cur_y | output | 12 | Cursor Y |
| win_x | output | 16 | Crosshair window X |
| win_y | output | 16 | Crosshair window Y |
| win_w | output | 16 | Crosshair window width |
| win_h | output | 16 | Crosshair window height |

## Verification
Read data and the RAM strobes are combinational, so they are due in the strobe cycle itself. The bench drives each access just after a falling edge and samples rdata, ram_we, ram_re and ram_addr 2 ns later, still before the rising edge. A pointer step or register write lands at the rising edge that closes the strobe cycle, so the decoded outputs are checked one full cycle after the write is driven. The effect on the pointer is read back only through a later port 0/1 read.

// File: rtl/curs_pkg.sv
package curs_pkg;
  typedef enum logic [1:0] {
    PORT_ADDR_LO = 2'd0,
    PORT_ADDR_HI = 2'd1,
    PORT_RAM     = 2'd2,
    PORT_REG     = 2'd3
  } port_e;

  localparam int unsigned CTRL_COUNT = 13;
  localparam int unsigned IDX_CMD    = 0;
  localparam int unsigned IDX_CXH    = 2;
  localparam int unsigned IDX_CYH    = 4;

  typedef struct packed {
    logic       cursor_on;
    logic       xhair_on;
    logic       or_mode;
    logic [1:0] mux_mode;
    logic [1:0] thick;
  } cmd_t;

  function automatic logic [7:0] keep_mask(input int unsigned idx);
    if (idx == IDX_CXH || idx == IDX_CYH) return 8'h0F;
    else if (idx == IDX_CMD)              return 8'h7F;
    else                                  return 8'hFF;
  endfunction
endpackage

// File: rtl/curs_addr_ptr.sv
module curs_addr_ptr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic          step,
  input  logic [7:0]    byte_in,
  output logic [AW-1:0] ptr
);
  localparam int unsigned HIW = AW - 8;

  logic [AW-1:0] ptr_q, ptr_d;
  logic [7:0]    stage_q, stage_d;
  logic          pend_q, pend_d;

  always_comb begin
    ptr_d   = ptr_q;
    stage_d = stage_q;
    pend_d  = pend_q;
    if (lo_wr) begin
      stage_d = byte_in;
      pend_d  = 1'b1;
    end else if (hi_wr) begin
      if (pend_q) begin
        ptr_d  = {byte_in[HIW-1:0], stage_q};
        pend_d = 1'b0;
      end
    end else if (step) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      stage_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      stage_q <= stage_d;
      pend_q  <= pend_d;
    end
  end

  assign ptr = ptr_q;

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !lo_wr && !hi_wr) |=> (ptr == $past(ptr) + 1'b1));

  // R2
  hi_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !pend_q) |=> $stable(ptr));

  // R1
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> $stable(ptr));
endmodule

// File: rtl/curs_ctrl_regs.sv
module curs_ctrl_regs
  import curs_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] ptr,
  input  logic [7:0]    wbyte,
  output logic [7:0]    rbyte,
  output cmd_t          cmd,
  output logic [11:0]   cur_x,
  output logic [11:0]   cur_y,
  output logic [15:0]   win_x,
  output logic [15:0]   win_y,
  output logic [15:0]   win_w,
  output logic [15:0]   win_h
);
  localparam int unsigned IW = $clog2(CTRL_COUNT);

  logic [CTRL_COUNT-1:0][7:0] file_q, file_d;
  logic          hit;
  logic [IW-1:0] idx;

  assign hit = (ptr < AW'(CTRL_COUNT));
  assign idx = ptr[IW-1:0];

  always_comb begin
    file_d = file_q;
    if (wr_en && hit) begin
      for (int i = 0; i < CTRL_COUNT; i++) begin
        if (idx == IW'(i)) file_d[i] = wbyte & keep_mask(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) file_q <= '0;
    else        file_q <= file_d;
  end

  assign rbyte = hit ? file_q[idx] : 8'h00;

  assign cmd.cursor_on = file_q[0][6];
  assign cmd.xhair_on  = file_q[0][5];
  assign cmd.or_mode   = file_q[0][4];
  assign cmd.mux_mode  = file_q[0][3:2];
  assign cmd.thick     = file_q[0][1:0];
  assign cur_x = {file_q[2][3:0], file_q[1]};
  assign cur_y = {file_q[4][3:0], file_q[3]};
  assign win_x = {file_q[6],  file_q[5]};
  assign win_y = {file_q[8],  file_q[7]};
  assign win_w = {file_q[10], file_q[9]};
  assign win_h = {file_q[12], file_q[11]};

  // R7
  unimpl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(file_q));

  // R5
  coord_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (file_q[2][7:4] == 4'h0) && (file_q[4][7:4] == 4'h0));

  // R7
  unimpl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rbyte == 8'h00));
endmodule

// File: rtl/curs_ram_port.sv
module curs_ram_port #(
  parameter int unsigned AW     = 16,
  parameter int unsigned RAM_AW = 9
) (
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [AW-1:0]     ptr,
  input  logic [15:0]       wdata,
  input  logic [15:0]       ram_rdata,
  output logic              ram_we,
  output logic              ram_re,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [15:0]       ram_wdata,
  output logic [15:0]       rd_word
);
  logic in_range;

  assign in_range  = ((ptr >> RAM_AW) == '0);
  assign ram_we    = acc_wr && in_range;
  assign ram_re    = acc_rd && in_range;
  assign ram_addr  = ptr[RAM_AW-1:0];
  assign ram_wdata = wdata;
  assign rd_word   = ram_re ? ram_rdata : 16'h0000;
endmodule

// File: rtl/curs_regport.sv
module curs_regport
  import curs_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned RAM_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        port_sel,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              ram_we,
  output logic              ram_re,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [15:0]       ram_wdata,
  input  logic [15:0]       ram_rdata,
  output logic              cursor_on,
  output logic              xhair_on,
  output logic              or_mode,
  output logic [1:0]        mux_mode,
  output logic [1:0]        xhair_thick,
  output logic [11:0]       cur_x,
  output logic [11:0]       cur_y,
  output logic [15:0]       win_x,
  output logic [15:0]       win_y,
  output logic [15:0]       win_w,
  output logic [15:0]       win_h
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  port_e         sel;
  logic          wr, rd, step;
  logic [AW-1:0] ptr;
  logic [7:0]    reg_rbyte;
  logic [15:0]   ram_word;
  cmd_t          cmd;

  assign sel  = port_e'(port_sel);
  assign wr   = wr_stb;
  assign rd   = rd_stb && !wr_stb;
  assign step = (wr || rd) && (sel == PORT_RAM || sel == PORT_REG);

  curs_addr_ptr #(.AW(AW)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lo_wr   (wr && sel == PORT_ADDR_LO),
    .hi_wr   (wr && sel == PORT_ADDR_HI),
    .step    (step),
    .byte_in (wdata[7:0]),
    .ptr     (ptr)
  );

  curs_ctrl_regs #(.AW(AW)) u_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (wr && sel == PORT_REG),
    .ptr   (ptr),
    .wbyte (wdata[7:0]),
    .rbyte (reg_rbyte),
    .cmd   (cmd),
    .cur_x (cur_x),
    .cur_y (cur_y),
    .win_x (win_x),
    .win_y (win_y),
    .win_w (win_w),
    .win_h (win_h)
  );

  curs_ram_port #(.AW(AW), .RAM_AW(RAM_AW)) u_ram (
    .acc_wr    (wr && sel == PORT_RAM),
    .acc_rd    (rd && sel == PORT_RAM),
    .ptr       (ptr),
    .wdata     (wdata),
    .ram_rdata (ram_rdata),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .rd_word   (ram_word)
  );

  always_comb begin
    rdata = 16'h0000;
    if (rd) begin
      case (sel)
        PORT_ADDR_LO: rdata = {8'h00, ptr[7:0]};
        PORT_ADDR_HI: rdata = {8'h00, ptr[15:8]};
        PORT_RAM:     rdata = ram_word;
        default:      rdata = {8'h00, reg_rbyte};
      endcase
    end
  end

  assign cursor_on   = cmd.cursor_on;
  assign xhair_on    = cmd.xhair_on;
  assign or_mode     = cmd.or_mode;
  assign mux_mode    = cmd.mux_mode;
  assign xhair_thick = cmd.thick;

  // R8
  ram_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({ram_we, ram_re}));

  // R9
  ram_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ram_we || ram_re) |-> (ptr < AW'(2 ** RAM_AW)));

  // R3
  addr_port_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd && (sel == PORT_ADDR_LO || sel == PORT_ADDR_HI)) |=> $stable(ptr));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_int_n |-> (!cursor_on && !xhair_on && ptr == '0));
endmodule

// File: tb/curs_regport_bench.sv
`timescale 1ns/1ps
module curs_regport_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  port_sel;
  logic        wr_stb, rd_stb;
  logic [15:0] wdata, rdata;
  logic        ram_we, ram_re;
  logic [8:0]  ram_addr;
  logic [15:0] ram_wdata, ram_rdata;
  logic        cursor_on, xhair_on, or_mode;
  logic [1:0]  mux_mode, xhair_thick;
  logic [11:0] cur_x, cur_y;
  logic [15:0] win_x, win_y, win_w, win_h;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  curs_regport u_curs_regport (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata), .ram_we(ram_we),
    .ram_re(ram_re), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .cursor_on(cursor_on), .xhair_on(xhair_on),
    .or_mode(or_mode), .mux_mode(mux_mode), .xhair_thick(xhair_thick),
    .cur_x(cur_x), .cur_y(cur_y), .win_x(win_x), .win_y(win_y),
    .win_w(win_w), .win_h(win_h)
  );

  logic [15:0] mem [512];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
  assign ram_rdata = mem[ram_addr];

  logic        s_we, s_re;
  logic [8:0]  s_addr;
  logic [15:0] s_wd;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic is_wr, input logic [1:0] p, input logic [15:0] d,
                    output logic [15:0] got);
    @(negedge clk);
    port_sel = p; wdata = d; wr_stb = is_wr; rd_stb = !is_wr;
    #2;
    got = rdata; s_we = ram_we; s_re = ram_re; s_addr = ram_addr; s_wd = ram_wdata;
    @(posedge clk);
    #1;
    wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    logic [15:0] g;
    op(1'b1, 2'd0, {2{a[7:0]}}, g);
    op(1'b1, 2'd1, {2{a[15:8]}}, g);
  endtask

  task automatic rd_ptr(output logic [15:0] a);
    logic [15:0] lo, hi;
    op(1'b0, 2'd0, 16'h0, lo);
    op(1'b0, 2'd1, 16'h0, hi);
    a = {hi[7:0], lo[7:0]};
  endtask

  // {is_read, port, data, expected}
  localparam int NV = 18;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 2'd0, 16'h0101, 16'h0}, {1'b0, 2'd1, 16'h0000, 16'h0},
    {1'b0, 2'd3, 16'h3434, 16'h0}, {1'b0, 2'd3, 16'hF5F5, 16'h0},
    {1'b0, 2'd3, 16'hABAB, 16'h0}, {1'b0, 2'd3, 16'hFFFF, 16'h0},
    {1'b0, 2'd3, 16'h1111, 16'h0}, {1'b0, 2'd3, 16'h2222, 16'h0},
    {1'b0, 2'd0, 16'h0101, 16'h0}, {1'b0, 2'd1, 16'h0000, 16'h0},
    {1'b1, 2'd3, 16'h0000, 16'h0034}, {1'b1, 2'd3, 16'h0000, 16'h0005},
    {1'b1, 2'd3, 16'h0000, 16'h00AB}, {1'b1, 2'd3, 16'h0000, 16'h000F},
    {1'b1, 2'd3, 16'h0000, 16'h0011}, {1'b1, 2'd3, 16'h0000, 16'h0022},
    {1'b1, 2'd0, 16'h0000, 16'h0007}, {1'b1, 2'd1, 16'h0000, 16'h0000}
  };

  task automatic report;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    logic [15:0] g, a;
    for (int i = 0; i < 512; i++) mem[i] = 16'h0;
    rst_n = 1'b0; port_sel = 2'd0; wr_stb = 1'b0; rd_stb = 1'b0; wdata = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10 reset state
    chk("R10 outputs", {cursor_on, xhair_on, or_mode, mux_mode, xhair_thick}, 0);
    chk("R10 coords", {cur_x, cur_y, win_x}, 0);
    rd_ptr(a);
    chk("R10 pointer", a, 0);

    // table: R1 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      op(!VEC[i][34], VEC[i][33:32], VEC[i][31:16], g);
      if (VEC[i][34]) chk($sformatf("R4/R5/R3 vec %0d", i), g, VEC[i][15:0]);
    end
    chk("R5 cur_x", cur_x, 12'h534);
    chk("R5 cur_y", cur_y, 12'hFAB);
    chk("R4 win_x", win_x, 16'h2211);

    // R6 command decode, bit 7 dropped
    set_ptr(16'h0000);
    op(1'b1, 2'd3, 16'hF5F5, g);
    chk("R6 fields", {cursor_on, xhair_on, or_mode, mux_mode, xhair_thick}, 7'b1110101);
    set_ptr(16'h0000);
    op(1'b0, 2'd3, 16'h0, g);
    chk("R6 readback", g, 16'h0075);

    // R7 unimplemented
    set_ptr(16'h000C);
    op(1'b1, 2'd3, 16'h7777, g);
    op(1'b1, 2'd3, 16'h5A5A, g);
    set_ptr(16'h000D);
    op(1'b0, 2'd3, 16'h0, g);
    chk("R7 read zero", g, 16'h0000);
    chk("R7 win_h", win_h, 16'h7700);
    set_ptr(16'h1234);
    op(1'b1, 2'd3, 16'h0000, g);
    chk("R7 cmd untouched", cursor_on, 1'b1);

    // R2 orphan high write
    set_ptr(16'h0123);
    op(1'b1, 2'd1, 16'h4545, g);
    rd_ptr(a);
    chk("R2 pointer kept", a, 16'h0123);

    // R3 wrap
    set_ptr(16'hFFFF);
    op(1'b0, 2'd3, 16'h0, g);
    chk("R3 reg read at FFFF", g, 16'h0000);
    rd_ptr(a);
    chk("R3 wrap", a, 16'h0000);

    // R8 RAM window
    op(1'b1, 2'd2, 16'h0F0F, g);
    set_ptr(16'h01FE);
    op(1'b1, 2'd2, 16'hBEEF, g);
    chk("R8 we strobe", {s_we, s_addr, s_wd}, {1'b1, 9'h1FE, 16'hBEEF});
    op(1'b1, 2'd2, 16'hCAFE, g);
    set_ptr(16'h01FE);
    op(1'b0, 2'd2, 16'h0, g);
    chk("R8 read word", {s_re, g}, {1'b1, 16'hBEEF});
    op(1'b0, 2'd2, 16'h0, g);
    chk("R8 read next", g, 16'hCAFE);

    // R9 out of range
    op(1'b1, 2'd2, 16'h1234, g);
    chk("R9 no we", {s_we, s_re}, 2'b00);
    set_ptr(16'h0200);
    op(1'b0, 2'd2, 16'h0, g);
    chk("R9 read zero", {s_re, g}, 17'h0);
    rd_ptr(a);
    chk("R9 pointer stepped", a, 16'h0201);
    set_ptr(16'h0000);
    op(1'b0, 2'd2, 16'h0, g);
    chk("R9 word 0 intact", g, 16'h0F0F);

    // R10 reset mid run
    #3 rst_n = 1'b0;
    #10;
    chk("R10 async clear", {cursor_on, xhair_on, cur_x, win_h}, 0);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    rd_ptr(a);
    chk("R10 pointer clear", a, 16'h0000);

    report();
  end
endmodule